// File: doc/BRIEF.md
# Rotating Floating-Point Register Stack

This block stores eight 80-bit extended-precision values and lets two kinds of client reach the same storage. A stack-relative client names an element by its depth below the top of stack; the block adds a 3-bit top-of-stack pointer to that depth, modulo the entry count, to find the physical entry. A physical client names the entry itself, and its accesses never see the rotation.

Each addressing mode has one combinational read port and one write port. The pointer register moves by one on push or pop, or is set to any value by a direct load. Its current value is always available on an output. Writes land on the clock edge and show up on reads from the next cycle. Arithmetic, tag tracking and stack faults belong to other blocks.

Top module: `fp_rot_stack`

## Requirements
- R1: After synchronous reset the pointer output is 0 and every entry reads as zero through both read ports.
- R2: A stack-relative read of depth N returns physical entry (pointer + N) modulo 8, using the pointer value held in that cycle.
- R3: A physical read of index k returns entry k and a physical write to index k updates entry k, for any pointer value.
- R4: A stack-relative write of depth N updates entry (base + N) modulo 8. The new value is not visible on reads in the same cycle, and it is visible from the next cycle on.
- R5: Push alone (no pop, no load) decrements the pointer modulo 8, so 0 becomes 7. A stack-relative write in that cycle uses the decremented pointer as its base.
- R6: Pop alone increments the pointer modulo 8, so 7 becomes 0. A stack-relative read in that cycle still uses the pointer from before the pop.
- R7: Push and pop together leave the pointer unchanged. A stack-relative write in that cycle uses the current pointer.
- R8: Direct load sets the pointer to the 3-bit load value and overrides push and pop. A stack-relative write in a load cycle uses the pointer from before the load.
- R9: When a stack-relative write and a physical write address the same entry in one cycle, the entry takes the physical write data.
- R10: The pointer output always shows the current pointer register value, and all 80 data bits are stored and returned unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push | input | 1 | Decrement the pointer |
| pop | input | 1 | Increment the pointer |
| tos_load | input | 1 | Load the pointer directly |
| tos_load_val | input | 3 | Value for the direct load |
| tos | output | 3 | Current top-of-stack pointer |
| st_rd_idx | input | 3 | Stack-relative read depth |
| st_rd_data | output | 80 | Stack-relative read data |
| st_wr_en | input | 1 | Stack-relative write enable |
| st_wr_idx | input | 3 | Stack-relative write depth |
| st_wr_data | input | 80 | Stack-relative write data |
| ph_rd_idx | input | 3 | Physical read index |
| ph_rd_data | output | 80 | Physical read data |
| ph_wr_en | input | 1 | Physical write enable |
| ph_wr_idx | input | 3 | Physical write index |
| ph_wr_data | input | 80 | Physical write data |

## Verification
The bench builds the block with its default parameters: eight entries, 80-bit data and a 3-bit pointer. At that size every pointer value and both wrap directions, 0 to 7 on push and 7 to 0 on pop, are reachable in a few dozen cycles. Every depth can be read at several pointer values, and full-width patterns show whether the upper sign-and-exponent bits survive storage. The reference model tracks the pointer and array from the requirements. It checks both read ports and the pointer output on every cycle, including the same-cycle collision and the push-with-write, pop-with-read and load-with-write orderings.

// File: rtl/fp_rot_stack_pkg.sv
package fp_rot_stack_pkg;

    localparam int unsigned FPS_DEPTH = 8;
    localparam int unsigned FPS_WIDTH = 80;

    typedef enum logic [1:0] {
        PTR_HOLD = 2'd0,
        PTR_DEC  = 2'd1,
        PTR_INC  = 2'd2,
        PTR_LOAD = 2'd3
    } ptr_op_e;

    function automatic ptr_op_e decode_ptr_op(input logic push, input logic pop, input logic load);
        if (load)               return PTR_LOAD;
        else if (push && !pop)  return PTR_DEC;
        else if (pop && !push)  return PTR_INC;
        else                    return PTR_HOLD;
    endfunction

endpackage

// File: rtl/fps_ptr_ctrl.sv
module fps_ptr_ctrl
    import fp_rot_stack_pkg::*;
#(
    parameter int unsigned PW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic          pop,
    input  logic          load,
    input  logic [PW-1:0] load_val,
    output logic [PW-1:0] ptr,
    output logic [PW-1:0] wr_base
);

    ptr_op_e       op;
    logic [PW-1:0] ptr_q;
    logic [PW-1:0] ptr_d;

    always_comb begin
        op = decode_ptr_op(push, pop, load);
        unique case (op)
            PTR_LOAD: ptr_d = load_val;
            PTR_DEC:  ptr_d = ptr_q - PW'(1);
            PTR_INC:  ptr_d = ptr_q + PW'(1);
            default:  ptr_d = ptr_q;
        endcase
        wr_base = (op == PTR_DEC) ? ptr_q - PW'(1) : ptr_q;
    end

    always_ff @(posedge clk) begin
        if (rst) ptr_q <= '0;
        else     ptr_q <= ptr_d;
    end

    assign ptr = ptr_q;

    // R8
    ptr_load_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> ptr_q == $past(load_val));

    // R5
    ptr_push_chk: assert property (@(posedge clk) disable iff (rst)
        (push && !pop && !load) |=> ptr_q == PW'($past(ptr_q) - PW'(1)));

    // R6
    ptr_pop_chk: assert property (@(posedge clk) disable iff (rst)
        (pop && !push && !load) |=> ptr_q == PW'($past(ptr_q) + PW'(1)));

    // R7
    ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && (push == pop)) |=> $stable(ptr_q));

endmodule

// File: rtl/fps_addr_xlate.sv
module fps_addr_xlate #(
    parameter int unsigned PW = 3
) (
    input  logic [PW-1:0] base,
    input  logic [PW-1:0] depth,
    output logic [PW-1:0] phys
);
    // Entry count is a power of two, so truncation gives the modulo.
    assign phys = base + depth;
endmodule

// File: rtl/fps_regfile.sv
module fps_regfile #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned WIDTH = 80,
    localparam int unsigned PW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PW-1:0]    a_rd_addr,
    output logic [WIDTH-1:0] a_rd_data,
    input  logic [PW-1:0]    b_rd_addr,
    output logic [WIDTH-1:0] b_rd_data,
    input  logic             lo_wr_en,
    input  logic [PW-1:0]    lo_wr_addr,
    input  logic [WIDTH-1:0] lo_wr_data,
    input  logic             hi_wr_en,
    input  logic [PW-1:0]    hi_wr_addr,
    input  logic [WIDTH-1:0] hi_wr_data
);

    logic [WIDTH-1:0] mem [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        logic hit_hi;
        logic hit_lo;
        assign hit_hi = hi_wr_en && (hi_wr_addr == PW'(g));
        assign hit_lo = lo_wr_en && (lo_wr_addr == PW'(g));

        always_ff @(posedge clk) begin
            if (rst)         mem[g] <= '0;
            else if (hit_hi) mem[g] <= hi_wr_data;
            else if (hit_lo) mem[g] <= lo_wr_data;
        end
    end

    assign a_rd_data = mem[a_rd_addr];
    assign b_rd_data = mem[b_rd_addr];

    // R9
    wr_collide_chk: assert property (@(posedge clk) disable iff (rst)
        (hi_wr_en && lo_wr_en && hi_wr_addr == lo_wr_addr)
        |=> mem[$past(hi_wr_addr)] == $past(hi_wr_data));

    // R3
    hi_write_chk: assert property (@(posedge clk) disable iff (rst)
        hi_wr_en |=> mem[$past(hi_wr_addr)] == $past(hi_wr_data));

    // R4
    lo_write_chk: assert property (@(posedge clk) disable iff (rst)
        (lo_wr_en && !(hi_wr_en && hi_wr_addr == lo_wr_addr))
        |=> mem[$past(lo_wr_addr)] == $past(lo_wr_data));

endmodule

// File: rtl/fp_rot_stack.sv
module fp_rot_stack
    import fp_rot_stack_pkg::*;
#(
    parameter int unsigned DEPTH = FPS_DEPTH,
    parameter int unsigned WIDTH = FPS_WIDTH,
    localparam int unsigned PW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             pop,
    input  logic             tos_load,
    input  logic [PW-1:0]    tos_load_val,
    output logic [PW-1:0]    tos,
    input  logic [PW-1:0]    st_rd_idx,
    output logic [WIDTH-1:0] st_rd_data,
    input  logic             st_wr_en,
    input  logic [PW-1:0]    st_wr_idx,
    input  logic [WIDTH-1:0] st_wr_data,
    input  logic [PW-1:0]    ph_rd_idx,
    output logic [WIDTH-1:0] ph_rd_data,
    input  logic             ph_wr_en,
    input  logic [PW-1:0]    ph_wr_idx,
    input  logic [WIDTH-1:0] ph_wr_data
);

    logic [PW-1:0] ptr;
    logic [PW-1:0] wr_base;
    logic [PW-1:0] st_rd_phys;
    logic [PW-1:0] st_wr_phys;

    fps_ptr_ctrl #(.PW(PW)) u_ptr (
        .clk      (clk),
        .rst      (rst),
        .push     (push),
        .pop      (pop),
        .load     (tos_load),
        .load_val (tos_load_val),
        .ptr      (ptr),
        .wr_base  (wr_base)
    );

    fps_addr_xlate #(.PW(PW)) u_rd_xlate (
        .base  (ptr),
        .depth (st_rd_idx),
        .phys  (st_rd_phys)
    );

    fps_addr_xlate #(.PW(PW)) u_wr_xlate (
        .base  (wr_base),
        .depth (st_wr_idx),
        .phys  (st_wr_phys)
    );

    fps_regfile #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_rf (
        .clk        (clk),
        .rst        (rst),
        .a_rd_addr  (st_rd_phys),
        .a_rd_data  (st_rd_data),
        .b_rd_addr  (ph_rd_idx),
        .b_rd_data  (ph_rd_data),
        .lo_wr_en   (st_wr_en),
        .lo_wr_addr (st_wr_phys),
        .lo_wr_data (st_wr_data),
        .hi_wr_en   (ph_wr_en),
        .hi_wr_addr (ph_wr_idx),
        .hi_wr_data (ph_wr_data)
    );

    assign tos = ptr;

    // R2
    rd_depth0_chk: assert property (@(posedge clk) disable iff (rst)
        (st_rd_idx == ph_rd_idx - tos) |-> st_rd_data == ph_rd_data);

endmodule

// File: tb/fp_rot_stack_tb.sv
module fp_rot_stack_tb;

    localparam int unsigned DEPTH = 8;
    localparam int unsigned WIDTH = 80;
    localparam int unsigned PW    = 3;

    typedef struct {
        string            tag;
        logic [WIDTH-1:0] exp_st;
        logic [WIDTH-1:0] exp_ph;
        logic [PW-1:0]    exp_tos;
    } exp_item_t;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             push = 1'b0, pop = 1'b0, tos_load = 1'b0;
    logic [PW-1:0]    tos_load_val = '0;
    logic [PW-1:0]    tos;
    logic [PW-1:0]    st_rd_idx = '0, st_wr_idx = '0, ph_rd_idx = '0, ph_wr_idx = '0;
    logic             st_wr_en = 1'b0, ph_wr_en = 1'b0;
    logic [WIDTH-1:0] st_wr_data = '0, ph_wr_data = '0;
    logic [WIDTH-1:0] st_rd_data, ph_rd_data;

    logic [WIDTH-1:0] model [DEPTH];
    logic [PW-1:0]    m_tos;
    exp_item_t        exp_q [$];
    int               n_checks = 0;
    int               n_fail   = 0;
    bit               finished = 1'b0;

    always #5 clk = ~clk;

    fp_rot_stack #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_dut (
        .clk(clk), .rst(rst), .push(push), .pop(pop),
        .tos_load(tos_load), .tos_load_val(tos_load_val), .tos(tos),
        .st_rd_idx(st_rd_idx), .st_rd_data(st_rd_data),
        .st_wr_en(st_wr_en), .st_wr_idx(st_wr_idx), .st_wr_data(st_wr_data),
        .ph_rd_idx(ph_rd_idx), .ph_rd_data(ph_rd_data),
        .ph_wr_en(ph_wr_en), .ph_wr_idx(ph_wr_idx), .ph_wr_data(ph_wr_data)
    );

    function automatic logic [WIDTH-1:0] pat(input int k);
        return {16'(16'hC000 + k * 16'h0111), 64'h8000_0000_0000_0000 | 64'(k * 64'h0123_4567)};
    endfunction

    // Monitor: compares each expected item against the live outputs.
    initial begin
        forever begin
            exp_item_t e;
            wait (exp_q.size() > 0);
            e = exp_q.pop_front();
            n_checks += 3;
            if (st_rd_data !== e.exp_st) begin
                n_fail++;
                $display("FAIL %s stack read: got %h expected %h", e.tag, st_rd_data, e.exp_st);
            end
            if (ph_rd_data !== e.exp_ph) begin
                n_fail++;
                $display("FAIL %s physical read: got %h expected %h", e.tag, ph_rd_data, e.exp_ph);
            end
            if (tos !== e.exp_tos) begin
                n_fail++;
                $display("FAIL %s pointer (R10): got %0d expected %0d", e.tag, tos, e.exp_tos);
            end
        end
    end

    // Driver: one clock cycle of stimulus, expected values from the model.
    task automatic cyc(input string tag,
                       input bit p_push, input bit p_pop, input bit p_ld, input int ldv,
                       input int lri, input bit lwe, input int lwi, input logic [WIDTH-1:0] lwd,
                       input int pri, input bit pwe, input int pwi, input logic [WIDTH-1:0] pwd);
        exp_item_t     e;
        logic [PW-1:0] base;
        @(negedge clk);
        push = p_push; pop = p_pop; tos_load = p_ld; tos_load_val = PW'(ldv);
        st_rd_idx = PW'(lri); st_wr_en = lwe; st_wr_idx = PW'(lwi); st_wr_data = lwd;
        ph_rd_idx = PW'(pri); ph_wr_en = pwe; ph_wr_idx = PW'(pwi); ph_wr_data = pwd;
        #1;
        e.tag     = tag;
        e.exp_st  = model[PW'(m_tos + PW'(lri))];
        e.exp_ph  = model[PW'(pri)];
        e.exp_tos = m_tos;
        exp_q.push_back(e);
        @(posedge clk);
        base = (!p_ld && p_push && !p_pop) ? PW'(m_tos - 1) : m_tos;
        if (lwe) model[PW'(base + PW'(lwi))] = lwd;
        if (pwe) model[PW'(pwi)] = pwd;
        if (p_ld)                 m_tos = PW'(ldv);
        else if (p_push && !p_pop) m_tos = PW'(m_tos - 1);
        else if (p_pop && !p_push) m_tos = PW'(m_tos + 1);
    endtask

    task automatic rd(input string tag, input int lri, input int pri);
        cyc(tag, 0, 0, 0, 0, lri, 0, 0, '0, pri, 0, 0, '0);
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) model[i] = '0;
        m_tos = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1: reset state through both ports
        for (int i = 0; i < DEPTH; i++) rd("R1 reset", i, i);

        // R3: fill through physical port, full-width patterns (R10)
        for (int i = 0; i < DEPTH; i++)
            cyc("R3 fill", 0, 0, 0, 0, 0, 0, 0, '0, 0, 1, i, pat(i));
        for (int i = 0; i < DEPTH; i++) rd("R3 readback R10", i, i);

        // R8: load pointer to 5, then R2 logical reads at every depth
        cyc("R8 load", 0, 0, 1, 5, 0, 0, 0, '0, 0, 0, 0, '0);
        for (int i = 0; i < DEPTH; i++) rd("R2 rotated read", i, i);

        // R3: physical write at nonzero pointer hits the named entry
        cyc("R3 phys write", 0, 0, 0, 0, 3, 1, 0, '0, 0, 1, 1, pat(40));
        rd("R3 phys readback", 4, 1);

        // R4: logical write depth 2 at pointer 5 -> entry 7; not visible same cycle
        cyc("R4 same cycle", 0, 0, 0, 0, 2, 1, 2, pat(50), 7, 0, 0, '0);
        rd("R4 next cycle", 2, 7);

        // R5: pushes with writes to depth 0, wrapping 0 -> 7
        for (int i = 0; i < 7; i++)
            cyc("R5 push", 1, 0, 0, 0, 0, 1, 0, pat(60 + i), i, 0, 0, '0);
        for (int i = 0; i < DEPTH; i++) rd("R5 after push", i, i);

        // R6: pops reading depth 0, wrapping 7 -> 0
        for (int i = 0; i < 4; i++)
            cyc("R6 pop", 0, 1, 0, 0, 0, 0, 0, '0, i, 0, 0, '0);
        cyc("R8 load 7", 0, 0, 1, 7, 1, 0, 0, '0, 0, 0, 0, '0);
        cyc("R6 pop wrap", 0, 1, 0, 0, 0, 0, 0, '0, 7, 0, 0, '0);
        rd("R6 after wrap", 0, 0);

        // R7: push and pop together replace the top
        cyc("R7 push+pop", 1, 1, 0, 0, 0, 1, 0, pat(80), 0, 0, 0, '0);
        rd("R7 result", 0, 0);

        // R8: load beats push; write uses the pointer from before the load
        cyc("R8 load+push", 1, 0, 1, 3, 1, 1, 1, pat(90), 1, 0, 0, '0);
        rd("R8 result", 0, 1);
        cyc("R8 load+pop", 0, 1, 1, 6, 0, 0, 0, '0, 3, 0, 0, '0);
        rd("R8 pointer", 0, 6);

        // R9: same-entry collision, physical data wins
        cyc("R9 collide", 0, 0, 0, 0, 0, 1, 2, pat(100), 0, 1, 0, pat(101));
        rd("R9 result", 2, 0);
        // R9: different entries both land
        cyc("R9 no collide", 0, 0, 0, 0, 0, 1, 3, pat(110), 0, 1, 2, pat(111));
        for (int i = 0; i < DEPTH; i++) rd("R9 final sweep", i, i);

        wait (exp_q.size() == 0);
        #1;
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule